// File: doc/BRIEF.md
# Operation and Standard Event Status Unit

This block reports instrument status to a host. A 16-bit operation condition word is sampled every clock, and a per-bit transition filter chooses whether a rise, a fall, both or neither of each implemented bit is recorded. Recorded transitions collect in a sticky event register. An enable mask then ANDs the event register and ORs the result into a single summary bit, which a service-request stage elsewhere can use.

Beside it sits an 8-bit standard event register with fixed bit meanings. A command decoder sets its bits with single-cycle pulses. The register has its own enable mask and its own summary bit. A small register port gives read and write access. Reading either event register returns its contents and clears it in the same cycle. A clear-all strobe empties both event registers. A preset strobe puts the operation filter and enable back to their defaults.

Top module: `status_group_top`

## Requirements
- R1: The operation condition register samples `cond_i` every clock. Only bits 0, 6, 8 and 9 (mask 0x0341) are implemented, and the other bits read as zero. Read data appears on `rdata_o` one clock after `rd_i` and holds until the next read.
- R2: A rising edge of an implemented condition bit whose positive filter bit is 1 sets that bit in the operation event register. The bit stays set until it is cleared.
- R3: A falling edge of an implemented condition bit whose negative filter bit is 1 sets that event bit. An edge whose filter bit is 0 leaves the event register unchanged.
- R4: A read of the operation event register (address 1) returns the value it held before the read and clears it. An event that arrives in the same cycle as the read stays in the register.
- R5: `clear_all_i` clears both the operation and the standard event registers. Events that arrive in the same cycle are kept.
- R6: `op_summary_o` is 1 exactly when some bit is set in both the operation event register and the operation enable register.
- R7: The operation enable register (address 2) is 0 after reset and stores writes ANDed with 0x0341. Writing 0 clears it.
- R8: Reset and `preset_i` set the operation enable register to 0x0000, the positive filter (address 3) to 0xFFFF and the negative filter (address 4) to 0x0000. `preset_i` takes priority over a write in the same cycle.
- R9: The standard event register (address 5, bits 7:0) records pulses as follows: `opc_i` sets bit 0, `qry_err_i` sets bit 2, `dev_err_i` sets bit 3, `exe_err_i` sets bit 4 and `cmd_err_i` sets bit 5. Bits 6 and 1 always read 0. Reading address 5 returns the value and clears it.
- R10: Bit 7 of the standard event register is 1 when reset ends. Once it is cleared it never sets again.
- R11: `std_summary_o` is 1 exactly when some bit is set in both the standard event register and the standard enable register (address 6, bits 7:0, reset 0).
- R12: Address 0 is the condition register and address 7 reads 0. On reads of 8-bit registers, bits 15:8 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 16 | Operation condition word |
| opc_i | input | 1 | Operation-complete pulse |
| qry_err_i | input | 1 | Query error pulse |
| dev_err_i | input | 1 | Device-dependent error pulse |
| exe_err_i | input | 1 | Parameter-range error pulse |
| cmd_err_i | input | 1 | Bad header / unsupported common command pulse |
| clear_all_i | input | 1 | Clear both event registers |
| preset_i | input | 1 | Restore operation filter and enable defaults |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| op_summary_o | output | 1 | Operation summary bit |
| std_summary_o | output | 1 | Standard event summary bit |

## Verification
The assertions assume that `cond_i` is synchronous to `clk` and that the strobes are single-clock levels sampled at the edge. They also assume that a read of an event register and a clear-all in the same cycle act as one clear. The bench drives every input on the falling edge, so values are stable at each rising edge. It draws conditions, pulses, strobes and register accesses from a seeded generator, and that includes reads and writes landing in the same cycle as edges, presets and clears.

// File: rtl/status_pkg.sv
// status_pkg: shared constants and the register address map of the status unit.
// Assumes a 3-bit address space, fully decoded.
package status_pkg;

    localparam int ADDR_W = 3;
    localparam int STD_W  = 8;

    // Register address map
    typedef enum logic [ADDR_W-1:0] {
        A_COND    = 3'd0,
        A_OP_EVT  = 3'd1,
        A_OP_EN   = 3'd2,
        A_POS_FLT = 3'd3,
        A_NEG_FLT = 3'd4,
        A_STD_EVT = 3'd5,
        A_STD_EN  = 3'd6,
        A_SPARE   = 3'd7
    } reg_addr_e;

    // Standard event bit positions
    localparam int BIT_DONE = 0;
    localparam int BIT_QRY  = 2;
    localparam int BIT_DEV  = 3;
    localparam int BIT_EXEC = 4;
    localparam int BIT_CMD  = 5;
    localparam int BIT_PWR  = 7;

endpackage

// File: rtl/status_reg_port.sv
// status_reg_port: decodes register writes into per-register strobes, raises
// read-and-clear strobes for the event registers and registers the read data.
// Assumes the register values presented are the pre-update values of the cycle.
module status_reg_port
    import status_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [OP_W-1:0]   cond_q,
    input  logic [OP_W-1:0]   op_evt,
    input  logic [OP_W-1:0]   op_en,
    input  logic [OP_W-1:0]   pos_flt,
    input  logic [OP_W-1:0]   neg_flt,
    input  logic [STD_W-1:0]  std_evt,
    input  logic [STD_W-1:0]  std_en,
    output logic              wr_op_en,
    output logic              wr_pos,
    output logic              wr_neg,
    output logic              wr_std_en,
    output logic              rd_op_evt,
    output logic              rd_std_evt,
    output logic [OP_W-1:0]   rdata_o
);

    localparam int PAD_W = OP_W - STD_W;

    reg_addr_e       sel;
    logic [OP_W-1:0] rd_mux;

    // Interpret the raw address as a register selector
    always_comb sel = reg_addr_e'(addr_i);

    // Write strobes, one per writable register
    always_comb begin
        wr_op_en  = wr_i && (sel == A_OP_EN);
        wr_pos    = wr_i && (sel == A_POS_FLT);
        wr_neg    = wr_i && (sel == A_NEG_FLT);
        wr_std_en = wr_i && (sel == A_STD_EN);
    end

    // Read-and-clear strobes for the two event registers
    always_comb begin
        rd_op_evt  = rd_i && (sel == A_OP_EVT);
        rd_std_evt = rd_i && (sel == A_STD_EVT);
    end

    // Read multiplexer over the pre-update register values
    always_comb begin
        case (sel)
            A_COND:    rd_mux = cond_q;
            A_OP_EVT:  rd_mux = op_evt;
            A_OP_EN:   rd_mux = op_en;
            A_POS_FLT: rd_mux = pos_flt;
            A_NEG_FLT: rd_mux = neg_flt;
            A_STD_EVT: rd_mux = {{PAD_W{1'b0}}, std_evt};
            A_STD_EN:  rd_mux = {{PAD_W{1'b0}}, std_en};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/status_op_group.sv
// status_op_group: operation condition register, per-bit transition filter,
// sticky event register, enable mask and summary bit.
// Assumes cond_i is synchronous to clk; only bits set in IMPL exist.
module status_op_group #(
    parameter int              OP_W = 16,
    parameter logic [OP_W-1:0] IMPL = 16'h0341
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] cond_i,
    input  logic            clear_all_i,
    input  logic            preset_i,
    input  logic            rd_clr_i,
    input  logic            wr_en_i,
    input  logic            wr_pos_i,
    input  logic            wr_neg_i,
    input  logic [OP_W-1:0] wdata_i,
    output logic [OP_W-1:0] cond_q,
    output logic [OP_W-1:0] evt_q,
    output logic [OP_W-1:0] en_q,
    output logic [OP_W-1:0] pos_q,
    output logic [OP_W-1:0] neg_q,
    output logic            clr_o,
    output logic            summary_o
);

    localparam logic [OP_W-1:0] POS_DEFAULT = '1;
    localparam logic [OP_W-1:0] NEG_DEFAULT = '0;

    logic [OP_W-1:0] cond_live;
    logic [OP_W-1:0] hit;

    // Condition inputs reduced to the implemented bits
    always_comb cond_live = cond_i & IMPL;

    // Per-bit transition filter; unimplemented bits never report
    for (genvar b = 0; b < OP_W; b++) begin : g_flt
        if (IMPL[b]) begin : g_live
            assign hit[b] = (cond_live[b] & ~cond_q[b] & pos_q[b])
                          | (~cond_live[b] & cond_q[b] & neg_q[b]);
        end else begin : g_dead
            assign hit[b] = 1'b0;
        end
    end

    // One clear request from either the clear-all strobe or a read
    always_comb clr_o = clear_all_i | rd_clr_i;

    // Condition register doubles as the previous value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_live;
    end

    // Sticky event register: clear first, then merge this cycle's hits
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (clr_o ? '0 : evt_q) | hit;
    end

    // Enable mask: reset, preset or a write (masked to implemented bits)
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (preset_i) en_q <= '0;
        else if (wr_en_i)  en_q <= wdata_i & IMPL;
    end

    // Positive and negative filter enables with preset defaults
    always_ff @(posedge clk) begin
        if (!rst_n || preset_i) begin
            pos_q <= POS_DEFAULT;
            neg_q <= NEG_DEFAULT;
        end else begin
            if (wr_pos_i) pos_q <= wdata_i;
            if (wr_neg_i) neg_q <= wdata_i;
        end
    end

    // Summary bit from the masked event register
    always_comb summary_o = |(evt_q & en_q);

endmodule

// File: rtl/status_std_group.sv
// status_std_group: 8-bit standard event register with fixed bit meanings,
// its enable mask and summary bit. The power bit is set by reset only.
// Assumes the error and completion inputs are single-cycle pulses.
module status_std_group
    import status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opc_i,
    input  logic             qry_err_i,
    input  logic             dev_err_i,
    input  logic             exe_err_i,
    input  logic             cmd_err_i,
    input  logic             clear_all_i,
    input  logic             rd_clr_i,
    input  logic             wr_en_i,
    input  logic [STD_W-1:0] wdata_i,
    output logic [STD_W-1:0] evt_q,
    output logic [STD_W-1:0] en_q,
    output logic             summary_o
);

    localparam logic [STD_W-1:0] PWR_ONLY = STD_W'(1) << BIT_PWR;

    logic [STD_W-1:0] set_vec;
    logic             clr;

    // Place each pulse at its fixed bit position
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_DONE] = opc_i;
        set_vec[BIT_QRY]  = qry_err_i;
        set_vec[BIT_DEV]  = dev_err_i;
        set_vec[BIT_EXEC] = exe_err_i;
        set_vec[BIT_CMD]  = cmd_err_i;
    end

    // Combined clear request
    always_comb clr = clear_all_i | rd_clr_i;

    // Sticky event register; leaves reset with only the power bit set
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= PWR_ONLY;
        else        evt_q <= (clr ? '0 : evt_q) | set_vec;
    end

    // Enable mask, written whole
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_en_i) en_q <= wdata_i;
    end

    // Summary bit
    always_comb summary_o = |(evt_q & en_q);

endmodule

// File: rtl/status_group_top.sv
// status_group_top: status reporting unit. Joins the operation group, the
// standard event group and the register port.
// Assumes all inputs are synchronous to clk.
module status_group_top
    import status_pkg::*;
#(
    parameter int              OP_W    = 16,
    parameter logic [OP_W-1:0] OP_IMPL = 16'h0341
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   cond_i,
    input  logic              opc_i,
    input  logic              qry_err_i,
    input  logic              dev_err_i,
    input  logic              exe_err_i,
    input  logic              cmd_err_i,
    input  logic              clear_all_i,
    input  logic              preset_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [OP_W-1:0]   wdata_i,
    output logic [OP_W-1:0]   rdata_o,
    output logic              op_summary_o,
    output logic              std_summary_o
);

    logic [OP_W-1:0]  op_cond, op_evt, op_en, op_pos, op_neg;
    logic [STD_W-1:0] std_evt, std_en;
    logic             wr_op_en, wr_pos, wr_neg, wr_std_en;
    logic             rd_op_evt, rd_std_evt;
    logic             op_clr;

    status_reg_port #(.OP_W(OP_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .cond_q     (op_cond),
        .op_evt     (op_evt),
        .op_en      (op_en),
        .pos_flt    (op_pos),
        .neg_flt    (op_neg),
        .std_evt    (std_evt),
        .std_en     (std_en),
        .wr_op_en   (wr_op_en),
        .wr_pos     (wr_pos),
        .wr_neg     (wr_neg),
        .wr_std_en  (wr_std_en),
        .rd_op_evt  (rd_op_evt),
        .rd_std_evt (rd_std_evt),
        .rdata_o    (rdata_o)
    );

    status_op_group #(.OP_W(OP_W), .IMPL(OP_IMPL)) u_op (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_i      (cond_i),
        .clear_all_i (clear_all_i),
        .preset_i    (preset_i),
        .rd_clr_i    (rd_op_evt),
        .wr_en_i     (wr_op_en),
        .wr_pos_i    (wr_pos),
        .wr_neg_i    (wr_neg),
        .wdata_i     (wdata_i),
        .cond_q      (op_cond),
        .evt_q       (op_evt),
        .en_q        (op_en),
        .pos_q       (op_pos),
        .neg_q       (op_neg),
        .clr_o       (op_clr),
        .summary_o   (op_summary_o)
    );

    status_std_group u_std (
        .clk         (clk),
        .rst_n       (rst_n),
        .opc_i       (opc_i),
        .qry_err_i   (qry_err_i),
        .dev_err_i   (dev_err_i),
        .exe_err_i   (exe_err_i),
        .cmd_err_i   (cmd_err_i),
        .clear_all_i (clear_all_i),
        .rd_clr_i    (rd_std_evt),
        .wr_en_i     (wr_std_en),
        .wdata_i     (wdata_i[STD_W-1:0]),
        .evt_q       (std_evt),
        .en_q        (std_en),
        .summary_o   (std_summary_o)
    );

endmodule

// File: rtl/status_group_chk.sv
// status_group_chk: temporal properties of the status unit, bound to the top.
module status_group_chk #(
    parameter int OP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_i,
    input logic [2:0]      addr_i,
    input logic            preset_i,
    input logic            cmd_err_i,
    input logic            op_clr,
    input logic [OP_W-1:0] op_evt,
    input logic [OP_W-1:0] op_en,
    input logic [OP_W-1:0] op_pos,
    input logic [OP_W-1:0] op_neg,
    input logic [7:0]      std_evt,
    input logic            op_summary_o,
    input logic [OP_W-1:0] rdata_o
);

    // R2
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_clr |=> ((op_evt & $past(op_evt)) == $past(op_evt)));

    // R4
    rd_clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == 3'd1) |=> (rdata_o == $past(op_evt)));

    // R6
    op_summary_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_summary_o |-> (op_en != '0 && op_evt != '0));

    // R8
    preset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (op_en == '0 && op_pos == '1 && op_neg == '0));

    // R9
    cmd_err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_i |=> std_evt[5]);

    // R10
    pwr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !std_evt[7] |=> !std_evt[7]);

endmodule

bind status_group_top status_group_chk #(.OP_W(OP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_i         (rd_i),
    .addr_i       (addr_i),
    .preset_i     (preset_i),
    .cmd_err_i    (cmd_err_i),
    .op_clr       (op_clr),
    .op_evt       (op_evt),
    .op_en        (op_en),
    .op_pos       (op_pos),
    .op_neg       (op_neg),
    .std_evt      (std_evt),
    .op_summary_o (op_summary_o),
    .rdata_o      (rdata_o)
);

// File: tb/status_group_top_bench.sv
module status_group_top_bench;

    localparam logic [15:0] IMPL = 16'h0341;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cond_i = '0;
    logic        opc_i = 0, qry_err_i = 0, dev_err_i = 0, exe_err_i = 0, cmd_err_i = 0;
    logic        clear_all_i = 0, preset_i = 0, wr_i = 0, rd_i = 0;
    logic [2:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        op_summary_o, std_summary_o;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [15:0] m_cond, m_evt, m_en, m_pos, m_neg;
    logic [7:0]  m_std, m_std_en;

    always #4 clk = ~clk;

    status_group_top u_status_group_top (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i),
        .opc_i(opc_i), .qry_err_i(qry_err_i), .dev_err_i(dev_err_i),
        .exe_err_i(exe_err_i), .cmd_err_i(cmd_err_i),
        .clear_all_i(clear_all_i), .preset_i(preset_i),
        .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .op_summary_o(op_summary_o), .std_summary_o(std_summary_o)
    );

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cond;
            3'd1: return m_evt;
            3'd2: return m_en;
            3'd3: return m_pos;
            3'd4: return m_neg;
            3'd5: return {8'h00, m_std};
            3'd6: return {8'h00, m_std_en};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R1";
            3'd1: return "R4";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R3";
            3'd5: return "R9";
            3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cond = '0; m_evt = '0; m_en = '0; m_pos = 16'hFFFF; m_neg = '0;
        m_std = 8'h80; m_std_en = '0;
    endtask

    // One clock: drive at negedge, predict, then check after the rising edge
    task automatic cyc(input logic [15:0] c, input logic [4:0] pulses,
                       input logic clr, input logic pre,
                       input logic [2:0] a, input logic wr, input logic rd,
                       input logic [15:0] wd);
        logic [15:0] exp_rd, hit, cl;
        logic [7:0]  sset;
        @(negedge clk);
        cond_i = c;
        {cmd_err_i, exe_err_i, dev_err_i, qry_err_i, opc_i} = pulses;
        clear_all_i = clr; preset_i = pre;
        addr_i = a; wr_i = wr; rd_i = rd; wdata_i = wd;
        exp_rd = model_read(a);
        cl  = c & IMPL;
        hit = ((cl & ~m_cond & m_pos) | (~cl & m_cond & m_neg)) & IMPL;
        m_evt = ((clr || (rd && a == 3'd1)) ? 16'h0 : m_evt) | hit;
        m_cond = cl;
        sset = {2'b00, pulses[4], pulses[3], pulses[2], pulses[1], 1'b0, pulses[0]};
        m_std = ((clr || (rd && a == 3'd5)) ? 8'h00 : m_std) | sset;
        if (pre) begin
            m_en = '0; m_pos = 16'hFFFF; m_neg = '0;
        end else if (wr) begin
            if (a == 3'd2) m_en = wd & IMPL;
            if (a == 3'd3) m_pos = wd;
            if (a == 3'd4) m_neg = wd;
        end
        if (wr && a == 3'd6) m_std_en = wd[7:0];
        @(posedge clk);
        #1;
        if (rd) check16(read_tag(a), rdata_o, exp_rd);
        check16("R6", {15'd0, op_summary_o}, {15'd0, |(m_evt & m_en)});
        check16("R11", {15'd0, std_summary_o}, {15'd0, |(m_std & m_std_en)});
        @(negedge clk);
        clear_all_i = 0; preset_i = 0; wr_i = 0; rd_i = 0;
        {cmd_err_i, exe_err_i, dev_err_i, qry_err_i, opc_i} = '0;
    endtask

    task automatic rd_reg(input logic [2:0] a);
        cyc(m_cond, 5'd0, 1'b0, 1'b0, a, 1'b0, 1'b1, 16'h0);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        cyc(m_cond, 5'd0, 1'b0, 1'b0, a, 1'b1, 1'b0, d);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state
        rd_reg(3'd3); check16("R8", rdata_o, 16'hFFFF);
        rd_reg(3'd4); check16("R8", rdata_o, 16'h0000);
        rd_reg(3'd2); check16("R7", rdata_o, 16'h0000);
        rd_reg(3'd7); check16("R12", rdata_o, 16'h0000);
        rd_reg(3'd5); check16("R10", rdata_o, 16'h0080);
        rd_reg(3'd5); check16("R10", rdata_o, 16'h0000);

        // R1 condition masking
        cyc(16'hFFFF, 5'd0, 0, 0, 3'd0, 0, 0, 16'h0);
        rd_reg(3'd0); check16("R1", rdata_o, 16'h0341);

        // R2 rising edges latched (bits rose in the previous cycle)
        rd_reg(3'd1); check16("R2", rdata_o, 16'h0341);
        rd_reg(3'd1); check16("R4", rdata_o, 16'h0000);

        // R3 falling with negative filter only on bit 8
        wr_reg(3'd4, 16'h0100);
        cyc(16'h0000, 5'd0, 0, 0, 3'd0, 0, 0, 16'h0);
        rd_reg(3'd1); check16("R3", rdata_o, 16'h0100);

        // R4 read and new event in the same cycle
        cyc(16'h0001, 5'd0, 0, 0, 3'd1, 0, 1, 16'h0);
        check16("R4", rdata_o, 16'h0000);
        rd_reg(3'd1); check16("R4", rdata_o, 16'h0001);

        // R7 masking and zero write; R6 summary
        wr_reg(3'd2, 16'hFFFF);
        rd_reg(3'd2); check16("R7", rdata_o, 16'h0341);
        cyc(16'h0000, 5'd0, 0, 0, 3'd0, 0, 0, 16'h0);
        cyc(16'h0040, 5'd0, 0, 0, 3'd0, 0, 0, 16'h0);
        check16("R6", {15'd0, op_summary_o}, 16'h0001);
        wr_reg(3'd2, 16'h0000);
        check16("R7", {15'd0, op_summary_o}, 16'h0000);

        // R9 pulses and R5 clear-all
        cyc(m_cond, 5'b11111, 0, 0, 3'd0, 0, 0, 16'h0);
        rd_reg(3'd5); check16("R9", rdata_o, 16'h003D);
        cyc(m_cond, 5'b00010, 0, 0, 3'd0, 0, 0, 16'h0);
        wr_reg(3'd6, 16'hFF04);
        check16("R11", {15'd0, std_summary_o}, 16'h0001);
        cyc(m_cond, 5'd0, 1, 0, 3'd0, 0, 0, 16'h0);
        rd_reg(3'd5); check16("R5", rdata_o, 16'h0000);

        // R8 preset beats write
        cyc(m_cond, 5'd0, 0, 1, 3'd3, 1, 0, 16'h1234);
        rd_reg(3'd3); check16("R8", rdata_o, 16'hFFFF);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] c, wd;
            logic [4:0]  p;
            logic        clr, pre, wr, rd;
            logic [2:0]  a;
            c   = (($urandom % 4) == 0) ? 16'($urandom) : m_cond;
            p   = 5'($urandom) & 5'($urandom) & 5'($urandom);
            clr = ($urandom % 32) == 0;
            pre = ($urandom % 64) == 0;
            a   = 3'($urandom);
            wr  = ($urandom % 8) == 0;
            rd  = ($urandom % 3) == 0;
            wd  = (($urandom % 4) == 0) ? 16'h0 : 16'($urandom);
            cyc(c, p, clr, pre, a, wr, rd, wd);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule